// File: doc/BRIEF.md
# Hash Command and Status Register Unit

This block is the register front end of a memory-mapped hash accelerator. It sits on a 32-bit register bus addressed by word index. It holds four address and length registers, and it trims every written value with a per-register mask. It also holds a command register. A write to the command register is decoded into an algorithm code, a digest mode, a scatter-gather flag and an interrupt enable.

When the engine is idle and the algorithm selection is legal, the block issues a one-cycle start pulse to the downstream engine. The pulse carries the decoded fields and the current buffer addresses. The engine reports the end of its work on a done input.

Completion is recorded in a status word. The completion flag is cleared by writing 1 to it. A level interrupt follows that flag whenever the finished command asked for an interrupt. A command with an illegal algorithm starts nothing, but it still completes at once, so software always sees an end to every command it writes.

Top module: `hash_regfront`

## Requirements
- R1: After reset, every register reads as zero, `irq` is low and `start` is low.
- R2: Each register keeps only part of what is written to it. Source (word 0, byte offset 0x00) keeps bits [30:0]. Destination (word 1, 0x04) keeps bits [30:3]. Key buffer (word 2, 0x08) keeps bits [30:3]. Length (word 3, 0x0C) keeps bits [27:0]. Command (word 4, 0x10) keeps the bits under mask 0x00147FFF.
- R3: Command bits [6:4] select the algorithm, and the selection appears on `start_alg`. The mapping is: 000 gives MD5 (code 0), 010 gives SHA-1 (code 1), 100 gives SHA-224 (code 2), 101 gives SHA-256 (code 3) and 110 gives the 512-bit family. Values 001, 011 and 111 are illegal.
- R4: Command bits [11:10] are looked at only when the 512-bit family is selected. Within the family: 00 gives SHA-512 (code 4), 01 gives SHA-384 (code 5), 10 gives SHA-256 (code 3) and 11 is illegal.
- R5: Command bits [8:7] appear on `start_mode`. `start_accum` is high only when that field is exactly 10. Command bit 18 appears on `start_sg`.
- R6: A command write with a legal algorithm, made while the engine is idle, raises `start` for exactly one cycle in the cycle after the write. The pulse carries the decoded fields and the current source and destination registers. The engine is then busy until `eng_done`.
- R7: `eng_done` while busy sets status bit 9 (word 7, byte offset 0x1C) whatever the interrupt enable says. `irq` rises with it only if command bit 9 was set. `eng_done` while idle has no effect.
- R8: A command write with an illegal algorithm starts nothing. It sets status bit 9 in the cycle after the write, and it raises `irq` if command bit 9 was set.
- R9: Writing 1 to status bit 9 clears the flag and lowers `irq`. Writing 0 to it changes nothing. If a completion lands in the same cycle as the clear, the flag is set.
- R10: A command write made while the engine is busy is ignored. No start is issued and the command register keeps its old value.
- R11: Reads of words that are not implemented return zero. This covers the unused words 5 and 6 and every word from 8 (byte offset 0x20) upward. Writes to words 8 and above change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data appears on `rdata` one cycle later |
| addr | input | ADDR_W | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| eng_done | input | 1 | Engine reports that the running operation has finished |
| start | output | 1 | One-cycle request to the engine |
| start_alg | output | 3 | Decoded algorithm code |
| start_mode | output | 2 | Digest mode field |
| start_accum | output | 1 | Accumulate mode flag |
| start_sg | output | 1 | Scatter-gather enable |
| src_addr | output | 32 | Masked source address register |
| dst_addr | output | 32 | Masked destination address register |
| key_addr | output | 32 | Masked key buffer address register |
| src_len | output | 32 | Masked source length register |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can fall in the same cycle: the engine's completion, which sets the status flag, and a write-1 clear of that same flag. The bench drives `eng_done` and the status clear write on the same clock edge while an operation is in flight. It then expects the status read to show bit 9 still set and `irq` still high. A lost completion would show as a zero status read and a low interrupt.

// File: rtl/hash_front_pkg.sv
package hash_front_pkg;

    typedef enum logic [2:0] {
        ALG_MD5    = 3'd0,
        ALG_SHA1   = 3'd1,
        ALG_SHA224 = 3'd2,
        ALG_SHA256 = 3'd3,
        ALG_SHA512 = 3'd4,
        ALG_SHA384 = 3'd5
    } hash_alg_e;

    typedef struct packed {
        hash_alg_e  alg;
        logic [1:0] mode;
        logic       accum;
        logic       sg;
        logic       irq_en;
        logic       valid;
    } cmd_fields_t;

    localparam int unsigned CMD_SEL_LSB   = 4;
    localparam int unsigned CMD_MODE_LSB  = 7;
    localparam int unsigned CMD_IRQEN_BIT = 9;
    localparam int unsigned CMD_SUB_LSB   = 10;
    localparam int unsigned CMD_SG_BIT    = 18;
    localparam int unsigned STAT_DONE_BIT = 9;

    localparam logic [2:0] SEL_MD5    = 3'b000;
    localparam logic [2:0] SEL_SHA1   = 3'b010;
    localparam logic [2:0] SEL_SHA224 = 3'b100;
    localparam logic [2:0] SEL_SHA256 = 3'b101;
    localparam logic [2:0] SEL_FAMILY = 3'b110;

    localparam logic [1:0] MODE_ACCUM = 2'b10;

endpackage

// File: rtl/hash_cmd_decode.sv
module hash_cmd_decode
    import hash_front_pkg::*;
(
    input  logic [2:0]  sel,
    input  logic [1:0]  sub,
    input  logic [1:0]  mode,
    input  logic        sg,
    input  logic        irq_en,
    output cmd_fields_t fields
);

    always_comb begin
        fields        = '0;
        fields.mode   = mode;
        fields.accum  = (mode == MODE_ACCUM);
        fields.sg     = sg;
        fields.irq_en = irq_en;
        fields.valid  = 1'b1;
        unique case (sel)
            SEL_MD5:    fields.alg = ALG_MD5;
            SEL_SHA1:   fields.alg = ALG_SHA1;
            SEL_SHA224: fields.alg = ALG_SHA224;
            SEL_SHA256: fields.alg = ALG_SHA256;
            SEL_FAMILY: begin
                unique case (sub)
                    2'b00:   fields.alg = ALG_SHA512;
                    2'b01:   fields.alg = ALG_SHA384;
                    2'b10:   fields.alg = ALG_SHA256;
                    default: fields.valid = 1'b0;
                endcase
            end
            default: fields.valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/hash_done_tracker.sv
module hash_done_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_valid,
    input  logic accept_invalid,
    input  logic accept_irq_en,
    input  logic eng_done,
    input  logic clr_done,
    output logic busy,
    output logic done_flag,
    output logic irq
);

    typedef struct packed {
        logic busy;
        logic done;
        logic irq;
        logic ie;
    } trk_t;

    trk_t q, d;
    logic finish, complete, ie_eff;

    always_comb begin
        finish   = q.busy & eng_done;
        complete = finish | accept_invalid;
        ie_eff   = accept_invalid ? accept_irq_en : q.ie;
        d        = q;
        if (accept_valid) begin
            d.busy = 1'b1;
            d.ie   = accept_irq_en;
        end else if (finish) begin
            d.busy = 1'b0;
        end
        if (complete)      d.done = 1'b1;
        else if (clr_done) d.done = 1'b0;
        if (complete && ie_eff) d.irq = 1'b1;
        else if (clr_done)      d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = q.busy;
    assign done_flag = q.done;
    assign irq       = q.irq;

    // R7
    done_after_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done) |=> done_flag);

    // R7
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag);

    // R9
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !(busy && eng_done) && !accept_invalid) |=> (!done_flag && !irq));

    // R6
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_done) |=> busy);

endmodule

// File: rtl/hash_regfront.sv
module hash_regfront
    import hash_front_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter logic [31:0] SRC_MASK = 32'h7FFF_FFFF,
    parameter logic [31:0] DST_MASK = 32'h7FFF_FFF8,
    parameter logic [31:0] KEY_MASK = 32'h7FFF_FFF8,
    parameter logic [31:0] LEN_MASK = 32'h0FFF_FFFF,
    parameter logic [31:0] CMD_MASK = 32'h0014_7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              eng_done,
    output logic              start,
    output logic [2:0]        start_alg,
    output logic [1:0]        start_mode,
    output logic              start_accum,
    output logic              start_sg,
    output logic [31:0]       src_addr,
    output logic [31:0]       dst_addr,
    output logic [31:0]       key_addr,
    output logic [31:0]       src_len,
    output logic              irq
);

    localparam int unsigned NUM_AREG = 4;
    localparam int unsigned WINDOW   = 8;
    localparam logic [ADDR_W-1:0] W_CMD    = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] W_STATUS = ADDR_W'(7);
    localparam logic [ADDR_W-1:0] W_LIMIT  = ADDR_W'(WINDOW);
    localparam logic [NUM_AREG-1:0][31:0] AREG_MASK = {LEN_MASK, KEY_MASK, DST_MASK, SRC_MASK};

    typedef struct packed {
        logic [NUM_AREG-1:0][31:0] areg;
        logic [31:0]               cmd;
        logic [31:0]               rdata;
        logic                      start;
        hash_alg_e                 alg;
        logic [1:0]                mode;
        logic                      accum;
        logic                      sg;
    } front_t;

    front_t q, d;

    logic [NUM_AREG-1:0] areg_we;
    logic [31:0]         cmd_in;
    cmd_fields_t         dec;
    logic                busy, done_flag;
    logic                cmd_wr, accept, clr_done;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_AREG; gi++) begin : g_areg_we
            assign areg_we[gi] = wr_en && (addr == ADDR_W'(gi));
        end
    endgenerate

    assign cmd_in   = wdata & CMD_MASK;
    assign cmd_wr   = wr_en && (addr == W_CMD);
    assign accept   = cmd_wr && !busy;
    assign clr_done = wr_en && (addr == W_STATUS) && wdata[STAT_DONE_BIT];

    hash_cmd_decode u_dec (
        .sel    (cmd_in[CMD_SEL_LSB +: 3]),
        .sub    (cmd_in[CMD_SUB_LSB +: 2]),
        .mode   (cmd_in[CMD_MODE_LSB +: 2]),
        .sg     (cmd_in[CMD_SG_BIT]),
        .irq_en (cmd_in[CMD_IRQEN_BIT]),
        .fields (dec)
    );

    hash_done_tracker u_trk (
        .clk            (clk),
        .rst_n          (rst_n),
        .accept_valid   (accept && dec.valid),
        .accept_invalid (accept && !dec.valid),
        .accept_irq_en  (dec.irq_en),
        .eng_done       (eng_done),
        .clr_done       (clr_done),
        .busy           (busy),
        .done_flag      (done_flag),
        .irq            (irq)
    );

    always_comb begin
        d       = q;
        d.start = 1'b0;
        for (int i = 0; i < NUM_AREG; i++) begin
            if (areg_we[i]) d.areg[i] = wdata & AREG_MASK[i];
        end
        if (accept) begin
            d.cmd = cmd_in;
            if (dec.valid) begin
                d.start = 1'b1;
                d.alg   = dec.alg;
                d.mode  = dec.mode;
                d.accum = dec.accum;
                d.sg    = dec.sg;
            end
        end
        if (rd_en) begin
            d.rdata = '0;
            for (int i = 0; i < NUM_AREG; i++) begin
                if (addr == ADDR_W'(i)) d.rdata = q.areg[i];
            end
            if (addr == W_CMD)    d.rdata = q.cmd;
            if (addr == W_STATUS) d.rdata = 32'(done_flag) << STAT_DONE_BIT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata       = q.rdata;
    assign start       = q.start;
    assign start_alg   = q.alg;
    assign start_mode  = q.mode;
    assign start_accum = q.accum;
    assign start_sg    = q.sg;
    assign src_addr    = q.areg[0];
    assign dst_addr    = q.areg[1];
    assign key_addr    = q.areg[2];
    assign src_len     = q.areg[3];

    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> busy);

    // R8
    invalid_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && !dec.valid) |=> (!start && done_flag));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> (!start && $stable(q.cmd)));

    // R11
    outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr >= W_LIMIT) |=> (rdata == 32'h0));

endmodule

// File: tb/sim_hash_regfront.sv
module sim_hash_regfront;
    import hash_front_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        eng_done = 1'b0;
    logic        start;
    logic [2:0]  start_alg;
    logic [1:0]  start_mode;
    logic        start_accum, start_sg;
    logic [31:0] src_addr, dst_addr, key_addr, src_len;
    logic        irq;

    always #2 clk = ~clk;

    hash_regfront u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .eng_done(eng_done), .start(start),
        .start_alg(start_alg), .start_mode(start_mode), .start_accum(start_accum),
        .start_sg(start_sg), .src_addr(src_addr), .dst_addr(dst_addr),
        .key_addr(key_addr), .src_len(src_len), .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] src_cur = '0;
    logic [31:0] dst_cur = '0;

    logic [31:0] rd_exp[$];
    string       rd_tag[$];
    logic [79:0] st_exp[$];
    string       st_tag[$];
    logic        rd_pend = 1'b0;

    function automatic void check(string tag, logic [79:0] act, logic [79:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endfunction

    always @(posedge clk) rd_pend <= rd_en;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (rd_exp.size() == 0) check("R11 unexpected read data", 80'(rdata), 80'hDEAD);
            else check(rd_tag.pop_front(), 80'(rdata), 80'(rd_exp.pop_front()));
        end
        if (start) begin
            if (st_exp.size() == 0) check("R6 unexpected start", 80'(1), 80'(0));
            else check(st_tag.pop_front(),
                       80'({start_alg, start_mode, start_accum, start_sg, src_addr, dst_addr}),
                       st_exp.pop_front());
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] dat);
        wr_en = 1'b1; addr = a; wdata = dat;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
        rd_exp.push_back(exp);
        rd_tag.push_back(tag);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [31:0] cmdw(logic [2:0] sel, logic [1:0] sub,
                                         logic [1:0] mode, logic sg, logic ie);
        return (32'(sg) << 18) | (32'(sub) << 10) | (32'(ie) << 9) |
               (32'(mode) << 7) | (32'(sel) << 4);
    endfunction

    task automatic push_start(logic [31:0] w, logic [2:0] alg, string tag);
        st_exp.push_back(80'({alg, w[8:7], (w[8:7] == 2'b10), w[18], src_cur, dst_cur}));
        st_tag.push_back(tag);
    endtask

    task automatic op(logic [31:0] w, logic valid, logic [2:0] alg, string tag);
        if (valid) push_start(w, alg, tag);
        wr(6'd4, w);
        if (valid) begin
            rd(6'd7, 32'h0, "R6 no flag while busy");
            idle(2);
            eng_done = 1'b1;
            @(negedge clk);
            eng_done = 1'b0;
        end
        rd(6'd7, 32'h200, valid ? "R7 flag after done" : "R8 flag after illegal");
        check(valid ? "R7 irq level" : "R8 irq level", 80'(irq), 80'(w[9]));
        wr(6'd7, 32'h200);
        rd(6'd7, 32'h0, "R9 flag cleared");
        check("R9 irq cleared", 80'(irq), 80'(0));
    endtask

    initial begin
        logic [31:0] wa;
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;
        check("R1 irq after reset", 80'(irq), 80'(0));
        check("R1 start after reset", 80'(start), 80'(0));
        for (int i = 0; i < 8; i++) rd(6'(i), 32'h0, "R1 register zero");

        wr(6'd0, 32'hFFFF_FFFF); rd(6'd0, 32'h7FFF_FFFF, "R2 source mask");
        wr(6'd1, 32'hFFFF_FFFF); rd(6'd1, 32'h7FFF_FFF8, "R2 destination mask");
        wr(6'd2, 32'hFFFF_FFFF); rd(6'd2, 32'h7FFF_FFF8, "R2 key mask");
        wr(6'd3, 32'hFFFF_FFFF); rd(6'd3, 32'h0FFF_FFFF, "R2 length mask");
        wr(6'd4, 32'hFFFF_FFFF); rd(6'd4, 32'h0014_7FFF, "R2 command mask");
        rd(6'd7, 32'h200, "R8 all-ones command completes");
        wr(6'd7, 32'h200);

        wr(6'd0, 32'h8000_4321); src_cur = 32'h0000_4321;
        wr(6'd1, 32'hC000_2007); dst_cur = 32'h4000_2000;

        wr(6'd8, 32'hAAAA_5555);
        rd(6'd0, src_cur, "R11 no alias on write beyond window");
        rd(6'd8, 32'h0, "R11 read beyond window");
        rd(6'd63, 32'h0, "R11 read top word");
        rd(6'd5, 32'h0, "R11 unused word");

        op(cmdw(3'b000, 2'b00, 2'b00, 1'b0, 1'b1), 1'b1, 3'd0, "R3 md5 start");
        op(cmdw(3'b010, 2'b00, 2'b01, 1'b0, 1'b0), 1'b1, 3'd1, "R3 sha1 hmac start");
        op(cmdw(3'b100, 2'b00, 2'b10, 1'b1, 1'b1), 1'b1, 3'd2, "R5 sha224 accum sg start");
        op(cmdw(3'b101, 2'b00, 2'b11, 1'b0, 1'b0), 1'b1, 3'd3, "R5 sha256 key mode start");
        op(cmdw(3'b110, 2'b00, 2'b00, 1'b1, 1'b1), 1'b1, 3'd4, "R4 family sha512 start");
        op(cmdw(3'b110, 2'b01, 2'b10, 1'b0, 1'b0), 1'b1, 3'd5, "R4 family sha384 start");
        op(cmdw(3'b110, 2'b10, 2'b00, 1'b0, 1'b1), 1'b1, 3'd3, "R4 family sha256 start");
        op(cmdw(3'b000, 2'b11, 2'b00, 1'b0, 1'b0), 1'b1, 3'd0, "R4 sub ignored outside family");
        op(cmdw(3'b001, 2'b00, 2'b00, 1'b0, 1'b1), 1'b0, 3'd0, "R8");
        op(cmdw(3'b011, 2'b00, 2'b00, 1'b0, 1'b0), 1'b0, 3'd0, "R8");
        op(cmdw(3'b111, 2'b00, 2'b00, 1'b0, 1'b1), 1'b0, 3'd0, "R8");
        op(cmdw(3'b110, 2'b11, 2'b00, 1'b0, 1'b1), 1'b0, 3'd0, "R4");

        wa = cmdw(3'b010, 2'b00, 2'b00, 1'b0, 1'b1);
        push_start(wa, 3'd1, "R10 first command starts");
        wr(6'd4, wa);
        wr(6'd4, cmdw(3'b000, 2'b00, 2'b10, 1'b1, 1'b0));
        rd(6'd4, wa, "R10 command kept while busy");
        eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
        rd(6'd7, 32'h200, "R10 first command completes");
        check("R10 irq from first command", 80'(irq), 80'(1));
        wr(6'd7, 32'h200);

        wa = cmdw(3'b101, 2'b00, 2'b00, 1'b0, 1'b1);
        push_start(wa, 3'd3, "R9 collision start");
        wr(6'd4, wa);
        idle(1);
        eng_done = 1'b1; wr_en = 1'b1; addr = 6'd7; wdata = 32'h200;
        @(negedge clk);
        eng_done = 1'b0; wr_en = 1'b0;
        rd(6'd7, 32'h200, "R9 completion wins over clear");
        check("R9 irq kept on collision", 80'(irq), 80'(1));
        wr(6'd7, 32'h0);
        rd(6'd7, 32'h200, "R9 writing zero keeps flag");
        check("R9 irq kept on zero write", 80'(irq), 80'(1));
        wr(6'd7, 32'h200);
        eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
        rd(6'd7, 32'h0, "R7 done while idle ignored");
        check("R7 irq after idle done", 80'(irq), 80'(0));

        idle(3);
        check("R6 all starts seen", 80'(st_exp.size()), 80'(0));
        check("R11 all reads seen", 80'(rd_exp.size()), 80'(0));
        summary();
        $finish;
    end

endmodule